// File: doc/BRIEF.md
# Round-Robin Converter Scan Controller

This controller lets up to ten successive-approximation converters share one 8-bit data bus. Each converter has an active-low blank-and-convert line. Holding a line high keeps that converter idle, with its data outputs released. Taking the line low starts a conversion. When the conversion ends, the converter pulls its open-drain done flag low and drives the bus. The done flags are wired together into two status groups, and the controller sees one active-low level per group.

The controller visits the channels in a fixed round-robin order. For the selected channel it first waits for that channel's group status to show released (high), then waits for it to fall. After a settle delay it captures the bus. It presents the captured word with the channel index and a one-cycle valid pulse. In the same cycle it blanks the old channel and selects the next one. A channel that does not finish within a programmable number of cycles gets a timeout pulse and is skipped.

An overlap mode takes the next channel's line low as soon as completion is detected, so its conversion runs while the previous word is still being read. A small bounded window therefore has two lines low.

Top module: `scan_ctrl`

## Requirements
- R1: While reset is asserted, every blank-and-convert line is high (all converters blanked), and `valid_o` and `tout_o` are low.
- R2: Outside the overlap window, at most one line is low at any time, and no two converters drive the bus together.
- R3: Channels are served in the order 0, 1, …, N_CH-1, then wrap to 0. Each channel ends with exactly one event, either a valid pulse or a timeout pulse, and `ch_o` carries that channel's index.
- R4: On a valid pulse, `data_o` equals the value on `bus_i` at the capturing clock edge. That value is the word driven by the selected converter.
- R5: On every valid or timeout event, the served channel's line is already high and the following channel's line is low. In normal mode both changes take effect in the same clock edge.
- R6: Completion is read from group bit 0 for channels below GRP_SPLIT (5) and from group bit 1 otherwise. The bit is active low. The controller must first see the bit high after selection. The valid pulse is visible exactly SETTLE_CYC+3 cycles after the group bit falls (two synchronizer stages, one detect edge, SETTLE_CYC settle cycles).
- R7: If the selected channel has not been detected complete within TMO_CYC cycles of its line falling, `tout_o` pulses exactly TMO_CYC cycles after selection and the controller moves to the next channel. If completion is detected in the last cycle before expiry, it wins, and the channel ends with a valid pulse, not a timeout.
- R8: With `ovl_en_i` high, the next line goes low in the edge that detects completion, and exactly SETTLE_CYC cycles then pass with two lines low. This never exceeds OVL_MAX_CYC. With `ovl_en_i` low, no cycle has two lines low.
- R9: `valid_o` and `tout_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_en_i | input | 1 | Overlap mode: start the next conversion during readout |
| bus_i | input | 8 | Shared converter data bus |
| grp_rdy_n_i | input | 2 | Wired done flags of the two status groups, active low |
| bc_n_o | output | 10 | Blank-and-convert lines, one per channel, low selects |
| data_o | output | 8 | Captured word |
| ch_o | output | 4 | Channel index of the last event |
| valid_o | output | 1 | One-cycle pulse: `data_o` holds a new word |
| tout_o | output | 1 | One-cycle pulse: channel `ch_o` timed out |

## Verification
Completion detection and timeout expiry can both fall in the same clock cycle. The bench provokes this by giving one channel a conversion time of TMO_CYC-3 cycles, so that its synchronized status falls in the very cycle the timeout counter reaches its limit. It then gives another channel TMO_CYC-2 cycles, which lands one cycle too late. The first channel must end with a valid pulse carrying its correct word and the standard latency. The second must end with a timeout pulse exactly TMO_CYC cycles after selection. In both cases the handoff to the next channel must be unchanged.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM    = 2'd1,
        ST_WAIT   = 2'd2,
        ST_SETTLE = 2'd3
    } scan_st_e;
endpackage

// File: rtl/scan_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for the wired status groups; resets to released (high).
module scan_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/scan_chsel.sv
`timescale 1ns/1ps
// Channel arithmetic: wrap-around successor, status group and line masks.
module scan_chsel #(
    parameter int N_CH      = 10,
    parameter int GRP_SPLIT = 5,
    parameter int CH_W      = 4
) (
    input  logic [CH_W-1:0] cur_i,
    output logic [CH_W-1:0] nxt_o,
    output logic            grp_o,
    output logic [N_CH-1:0] cur_mask_n_o,
    output logic [N_CH-1:0] nxt_mask_n_o
);
    always_comb begin
        nxt_o = (cur_i == CH_W'(N_CH - 1)) ? '0 : cur_i + 1'b1;
        grp_o = (cur_i >= CH_W'(GRP_SPLIT));
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_mask
        assign cur_mask_n_o[g] = (cur_i != CH_W'(g));
        assign nxt_mask_n_o[g] = (nxt_o != CH_W'(g));
    end
endmodule

// File: rtl/scan_tmo.sv
`timescale 1ns/1ps
// Per-selection wait counter; flags expiry in the cycle it reaches LIM-1.
module scan_tmo #(
    parameter int LIM = 60,
    localparam int CW = $clog2(LIM + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (run_i && cnt_q != CW'(LIM))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = run_i && (cnt_q == CW'(LIM - 1));

    p_tmo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIM));
endmodule

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int N_CH        = 10,
    parameter int GRP_SPLIT   = 5,
    parameter int DW          = 8,
    parameter int SETTLE_CYC  = 2,
    parameter int TMO_CYC     = 60,
    parameter int OVL_MAX_CYC = 4,
    localparam int CH_W  = $clog2(N_CH),
    localparam int SET_W = $clog2(SETTLE_CYC + 1),
    localparam int OW    = $clog2(OVL_MAX_CYC + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ovl_en_i,
    input  logic [DW-1:0]   bus_i,
    input  logic [1:0]      grp_rdy_n_i,
    output logic [N_CH-1:0] bc_n_o,
    output logic [DW-1:0]   data_o,
    output logic [CH_W-1:0] ch_o,
    output logic            valid_o,
    output logic            tout_o
);
    typedef struct packed {
        scan_st_e         st;
        logic [CH_W-1:0]  cur;
        logic [SET_W-1:0] set_cnt;
        logic [N_CH-1:0]  bc;
        logic [DW-1:0]    data;
        logic [CH_W-1:0]  ch;
        logic             valid;
        logic             tout;
    } ctl_t;

    ctl_t d, q;

    logic [1:0]      grp_s;
    logic [CH_W-1:0] nxt;
    logic            grp_sel;
    logic [N_CH-1:0] cur_mask_n, nxt_mask_n;
    logic            tmo_clr, tmo_run, tmo_exp;
    logic            grp_lvl;

    scan_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (grp_rdy_n_i),
        .sync_o  (grp_s)
    );

    scan_chsel #(.N_CH(N_CH), .GRP_SPLIT(GRP_SPLIT), .CH_W(CH_W)) u_chsel (
        .cur_i        (q.cur),
        .nxt_o        (nxt),
        .grp_o        (grp_sel),
        .cur_mask_n_o (cur_mask_n),
        .nxt_mask_n_o (nxt_mask_n)
    );

    scan_tmo #(.LIM(TMO_CYC)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmo_clr),
        .run_i    (tmo_run),
        .expire_o (tmo_exp)
    );

    assign grp_lvl = grp_s[grp_sel];
    assign tmo_run = (q.st == ST_ARM) || (q.st == ST_WAIT);

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.tout  = 1'b0;
        tmo_clr = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.bc    = cur_mask_n;
                d.st    = ST_ARM;
                tmo_clr = 1'b1;
            end
            ST_ARM: begin
                if (tmo_exp) begin
                    d.tout  = 1'b1;
                    d.ch    = q.cur;
                    d.bc    = nxt_mask_n;
                    d.cur   = nxt;
                    tmo_clr = 1'b1;
                end else if (grp_lvl) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!grp_lvl) begin
                    d.st      = ST_SETTLE;
                    d.set_cnt = '0;
                    if (ovl_en_i) d.bc = q.bc & nxt_mask_n;
                end else if (tmo_exp) begin
                    d.tout  = 1'b1;
                    d.ch    = q.cur;
                    d.bc    = nxt_mask_n;
                    d.cur   = nxt;
                    d.st    = ST_ARM;
                    tmo_clr = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (q.set_cnt == SET_W'(SETTLE_CYC - 1)) begin
                    d.data  = bus_i;
                    d.ch    = q.cur;
                    d.valid = 1'b1;
                    d.bc    = nxt_mask_n;
                    d.cur   = nxt;
                    d.st    = ST_ARM;
                    tmo_clr = 1'b1;
                end else begin
                    d.set_cnt = q.set_cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cur: '0, set_cnt: '0, bc: '1,
                   data: '0, ch: '0, valid: 1'b0, tout: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign bc_n_o  = q.bc;
    assign data_o  = q.data;
    assign ch_o    = q.ch;
    assign valid_o = q.valid;
    assign tout_o  = q.tout;

    // Checking logic
    logic [CH_W-1:0] ev_nxt;
    logic [OW-1:0]   ovl_run_d, ovl_run_q;

    assign ev_nxt = (ch_o == CH_W'(N_CH - 1)) ? '0 : ch_o + 1'b1;

    always_comb begin
        ovl_run_d = '0;
        if ($countones(~bc_n_o) == 2)
            ovl_run_d = (ovl_run_q == OW'(OVL_MAX_CYC + 1)) ? ovl_run_q : ovl_run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovl_run_q <= '0;
        else        ovl_run_q <= ovl_run_d;
    end

    p_single_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_SETTLE) |-> ($countones(~bc_n_o) <= 1));

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (data_o == $past(bus_i)));

    p_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || tout_o) |-> (bc_n_o[ch_o] && !bc_n_o[ev_nxt]));

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && tout_o));

    p_pulse_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_pulse_tout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tout_o |=> !tout_o);

    p_ovl_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_run_q <= OW'(OVL_MAX_CYC));
endmodule

// File: tb/tb_scan_ctrl.sv
`timescale 1ns/1ps
module tb_scan_ctrl;
    localparam int N   = 10;
    localparam int SPL = 5;
    localparam int S   = 2;
    localparam int TMO = 60;
    localparam int REL = 3;
    localparam int NEV = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovl_en = 1'b0;
    logic [7:0] bus = 8'h00;
    logic [1:0] grp_n = 2'b11;
    logic [N-1:0] bc_n;
    logic [7:0] data;
    logic [3:0] ch;
    logic       valid, tout;

    always #2 clk = ~clk;

    scan_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovl_en_i    (ovl_en),
        .bus_i       (bus),
        .grp_rdy_n_i (grp_n),
        .bc_n_o      (bc_n),
        .data_o      (data),
        .ch_o        (ch),
        .valid_o     (valid),
        .tout_o      (tout)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0, events = 0, exp_ch = 0, ovl_cnt = 0;
    int bad_lines = 0, contention = 0, pulse_bad = 0, lows = 0, ndrv = 0, nx = 0;
    int ovr[N], cnt[N], starts[N], rel[N], visits[N], done_at[N], sel_at[N];
    bit busy[N], dn[N], drv[N], drn[N], prev_low[N];
    bit prev_valid = 0, prev_tout = 0, ln = 0, exp_to = 0;
    logic [7:0] val[N];

    function automatic int conv_of(int k);
        return (ovr[k] >= 0) ? ovr[k] : 20 + 3 * k;
    endfunction

    function automatic logic [7:0] val_of(int k, int r);
        return 8'((k * 37 + r * 11 + 5) % 256);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            ovr[k] = -1; cnt[k] = 0; starts[k] = 0; rel[k] = 0; visits[k] = 0;
            done_at[k] = 0; sel_at[k] = 0; busy[k] = 0; dn[k] = 0; drv[k] = 0;
            drn[k] = 1; prev_low[k] = 0; val[k] = 8'h00;
        end
        repeat (3) @(negedge clk);
        chk(bc_n == '1, "R1 lines blanked in reset", int'(bc_n), 1023);
        chk(valid == 1'b0, "R1 valid low in reset", int'(valid), 0);
        chk(tout == 1'b0, "R1 timeout low in reset", int'(tout), 0);
        rst_n = 1'b1;

        while (events < NEV && cyc < 100000) begin
            @(negedge clk);
            cyc++;
            lows = $countones(~bc_n);
            if (lows > 2 || (!ovl_en && lows > 1)) bad_lines++;
            if (lows == 2) ovl_cnt++;
            for (int k = 0; k < N; k++)
                if (!bc_n[k] && !prev_low[k]) sel_at[k] = cyc;
            if ((valid && prev_valid) || (tout && prev_tout) || (valid && tout)) pulse_bad++;

            if (valid || tout) begin
                nx = (exp_ch + 1) % N;
                exp_to = (events >= 30 && events < 40 && (exp_ch == 6 || exp_ch == 8));
                chk(int'(ch) == exp_ch, "R3 channel order", int'(ch), exp_ch);
                chk(bc_n[exp_ch] && !bc_n[nx] && lows == 1, "R5 handoff lines",
                    int'(bc_n), int'(~(10'd1 << nx)));
                chk(tout == exp_to, "R7 outcome timeout vs valid", int'(tout), int'(exp_to));
                if (valid) begin
                    chk(data == val_of(exp_ch, visits[exp_ch]), "R4 captured word",
                        int'(data), int'(val_of(exp_ch, visits[exp_ch])));
                    chk(cyc - done_at[exp_ch] == S + 3, "R6 status-to-valid latency",
                        cyc - done_at[exp_ch], S + 3);
                    chk(ovl_cnt == (ovl_en ? S : 0), "R8 cycles with two lines low",
                        ovl_cnt, ovl_en ? S : 0);
                end
                if (tout)
                    chk(cyc - sel_at[exp_ch] == TMO, "R7 timeout delay",
                        cyc - sel_at[exp_ch], TMO);
                visits[exp_ch]++;
                exp_ch = nx;
                events++;
                ovl_cnt = 0;
                if (events == 30) begin
                    ovr[3] = TMO - 3;   // completion meets expiry: completion wins
                    ovr[6] = TMO - 2;   // one cycle late: timeout
                    ovr[8] = 0;         // never completes
                end
                if (events == 40) begin
                    for (int k = 0; k < N; k++) ovr[k] = -1;
                    ovl_en = 1'b1;
                end
            end
            prev_valid = valid;
            prev_tout  = tout;

            // converter models
            for (int k = 0; k < N; k++) begin
                ln = !bc_n[k];
                if (ln && !prev_low[k]) begin
                    starts[k]++;
                    busy[k] = 1;
                    cnt[k] = 0;
                end else if (ln && busy[k]) begin
                    cnt[k]++;
                    if (cnt[k] == conv_of(k)) begin
                        busy[k] = 0;
                        dn[k] = 1;
                        drn[k] = 0;
                        val[k] = val_of(k, starts[k] - 1);
                        done_at[k] = cyc;
                    end
                end else if (ln && dn[k] && !drv[k]) begin
                    drv[k] = 1;
                end
                if (!ln) begin
                    busy[k] = 0;
                    if (dn[k]) begin
                        rel[k]++;
                        if (rel[k] == REL) begin
                            drn[k] = 1; drv[k] = 0; dn[k] = 0; rel[k] = 0;
                        end
                    end
                end
                prev_low[k] = ln;
            end
            ndrv = 0;
            bus = 8'h00;
            grp_n = 2'b11;
            for (int k = 0; k < N; k++) begin
                if (drv[k]) begin
                    ndrv++;
                    bus = val[k];
                end
                if (!drn[k]) grp_n[(k >= SPL) ? 1 : 0] = 1'b0;
            end
            if (ndrv > 1) contention++;
        end

        chk(events == NEV, "R3 all events seen before watchdog", events, NEV);
        chk(bad_lines == 0, "R2 selected line count", bad_lines, 0);
        chk(contention == 0, "R2 single bus driver", contention, 0);
        chk(pulse_bad == 0, "R9 single-cycle exclusive pulses", pulse_bad, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule